// File: doc/BRIEF.md
# Host Port DMA Handshake Engine

This block is the slave end of a host port that moves 32-bit words between an outside DMA bus master and a local DMA engine. The outside master works through a request pin and an acknowledge strobe. The local engine works through a matching request/acknowledge pair on the chip side. A three-bit control word selects the direction of transfer. Bit 0 selects inbound (master to local). Bit 1 selects outbound (local to master). Bit 2 selects an alternate mode, and it must be zero for DMA traffic. Any setting other than exactly one direction bit with bit 2 clear turns the port off.

Inbound, the master writes a holding register under acknowledge. When acknowledge drops, the word is staged. On the next cycle it moves into a receive register, provided that register is free. The move re-opens the holding register, which raises the outside request again. It also marks the receive register full, which raises the local request, so one outside transfer chains straight into one local transfer. Outbound, the local engine loads a send register. That raises the outside request, and an acknowledge-strobed read by the master drains the register.

Top module: `hdma_port`

## Requirements
- R1: While `rst` is high at a clock edge, the control word clears to 0, both holding registers become empty and the receive register becomes not-full. After that edge `ext_req`, `loc_req` and `ext_rdata` are all 0.
- R2: With control word 3'b001 (inbound), `ext_req` is 1 exactly when the holding register is empty.
- R3: In inbound mode the word on `ext_wdata` in the last cycle `ext_ack` is high is the word transferred. After the edge that samples `ext_ack` low, `ext_req` is 0. One edge later the word is in the receive register, and `loc_req` and `ext_req` are both 1.
- R4: In inbound mode `loc_rdata` shows the receive register. A cycle with `loc_ack` high while `loc_req` is 1 reads that word and clears `loc_req` at the next edge.
- R5: While the receive register is full, a newly written word waits in the holding register and `ext_req` stays 0. The word moves one edge after the receive register is read, and the waiting word is not lost or overwritten.
- R6: With control word 3'b010 (outbound), `loc_req` is 1 while the send register is empty. `loc_ack` loads `loc_wdata` into it, after which `loc_req` is 0 and `ext_req` is 1. A `loc_ack` while the register is full is ignored.
- R7: In outbound mode the master reads the word while holding `ext_ack` high. After the edge that samples `ext_ack` low, the register is empty, `ext_req` is 0 and `loc_req` is 1.
- R8: With bit 2 of the control word set, or with both direction bits set, both requests are 0 and `ext_ack`/`loc_ack` change no register.
- R9: `ext_rdata` is 0 unless the port is outbound and `ext_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Load the control word |
| ctl_wdata | input | 3 | Control word: bit0 inbound, bit1 outbound, bit2 alternate mode |
| ext_ack | input | 1 | Acknowledge strobe from the outside DMA master |
| ext_wdata | input | 32 | Write data from the master |
| ext_rdata | output | 32 | Read data to the master, driven during a strobed read |
| ext_req | output | 1 | DMA request to the outside master |
| loc_ack | input | 1 | Acknowledge from the local DMA engine |
| loc_wdata | input | 32 | Outbound word from the local engine |
| loc_rdata | output | 32 | Inbound word to the local engine |
| loc_req | output | 1 | Service request to the local DMA engine |

## Verification
The bench fills the receive register and then writes a second word. A design that moves that word anyway overwrites the first word, and the scoreboard sees a wrong or missing word. A design that raises the outside request early shows up as an `ext_req` mismatch during the stall. An acknowledge held over several cycles with changing data catches a design that latches the first word instead of the last. Acknowledges sent while the port is off, and a second local load into a full send register, catch designs that let a disabled or full path change state. A read-data bus that is not parked at zero is caught right after each strobed read.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

    localparam int unsigned HD_WIDTH = 32;

    typedef enum logic [1:0] {
        XFER_OFF = 2'd0,
        XFER_IN  = 2'd1,
        XFER_OUT = 2'd2
    } xfer_dir_e;

    typedef struct packed {
        logic alt_mode;
        logic dir_out;
        logic dir_in;
    } hd_ctl_t;

    typedef struct packed {
        logic hi;
        logic fall;
    } strobe_t;

    function automatic xfer_dir_e decode_dir(hd_ctl_t c);
        xfer_dir_e d;
        d = XFER_OFF;
        if (!c.alt_mode) begin
            case ({c.dir_out, c.dir_in})
                2'b01:   d = XFER_IN;
                2'b10:   d = XFER_OUT;
                default: d = XFER_OFF;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/hdma_ctl.sv
module hdma_ctl
    import hdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  logic [2:0] ctl_wdata,
    input  logic      ext_ack,
    output xfer_dir_e dir,
    output strobe_t   stb
);
    hd_ctl_t ctl_q;
    logic    ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ack_q <= 1'b0;
        end else begin
            if (ctl_wr) ctl_q <= hd_ctl_t'(ctl_wdata);
            ack_q <= ext_ack;
        end
    end

    assign dir     = decode_dir(ctl_q);
    assign stb.hi  = ext_ack;
    assign stb.fall = ack_q && !ext_ack;

endmodule

// File: rtl/hdma_inbound.sv
module hdma_inbound
    import hdma_pkg::*;
#(
    parameter int unsigned W = HD_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  strobe_t      stb,
    input  logic [W-1:0] wdata,
    input  logic         loc_ack,
    output logic [W-1:0] rdata,
    output logic         tx_free,
    output logic         rx_full
);
    logic [W-1:0] tx_q, rx_q;
    logic         tx_full_q, rx_full_q;
    logic         move;

    assign move = tx_full_q && !rx_full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q      <= '0;
            rx_q      <= '0;
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
        end else begin
            if (en && stb.hi && !tx_full_q) tx_q <= wdata;
            if (move) begin
                rx_q      <= tx_q;
                rx_full_q <= 1'b1;
                tx_full_q <= 1'b0;
            end else begin
                if (en && stb.fall) tx_full_q <= 1'b1;
                if (en && loc_ack && rx_full_q) rx_full_q <= 1'b0;
            end
        end
    end

    assign rdata   = rx_q;
    assign tx_free = !tx_full_q;
    assign rx_full = rx_full_q;

    AST_WAIT_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        (tx_full_q && rx_full_q) |=> tx_full_q); // R5
    AST_MOVE_CARRIES_WORD: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_full_q) |-> (rx_full_q && rx_q == $past(tx_q))); // R3
    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        (en && loc_ack && rx_full_q) |=> !rx_full_q); // R4

endmodule

// File: rtl/hdma_outbound.sv
module hdma_outbound
    import hdma_pkg::*;
#(
    parameter int unsigned W = HD_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ack_fall,
    input  logic         loc_ack,
    input  logic [W-1:0] loc_wdata,
    output logic [W-1:0] ob_data,
    output logic         ob_full
);
    logic [W-1:0] ob_q;
    logic         ob_full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ob_q      <= '0;
            ob_full_q <= 1'b0;
        end else if (en) begin
            if (loc_ack && !ob_full_q) begin
                ob_q      <= loc_wdata;
                ob_full_q <= 1'b1;
            end else if (ack_fall && ob_full_q) begin
                ob_full_q <= 1'b0;
            end
        end
    end

    assign ob_data = ob_q;
    assign ob_full = ob_full_q;

    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
        (en && loc_ack && !ob_full_q) |=> (ob_full_q && ob_q == $past(loc_wdata))); // R6
    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (en && ack_fall && ob_full_q) |=> !ob_full_q); // R7
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(ob_full_q) && $stable(ob_q))); // R8

endmodule

// File: rtl/hdma_port.sv
module hdma_port
    import hdma_pkg::*;
#(
    parameter int unsigned W = HD_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_wr,
    input  logic [2:0]   ctl_wdata,
    input  logic         ext_ack,
    input  logic [W-1:0] ext_wdata,
    output logic [W-1:0] ext_rdata,
    output logic         ext_req,
    input  logic         loc_ack,
    input  logic [W-1:0] loc_wdata,
    output logic [W-1:0] loc_rdata,
    output logic         loc_req
);
    xfer_dir_e    dir;
    strobe_t      stb;
    logic         in_en, out_en;
    logic         tx_free, rx_full, ob_full;
    logic [W-1:0] ob_data;

    hdma_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ext_ack   (ext_ack),
        .dir       (dir),
        .stb       (stb)
    );

    assign in_en  = (dir == XFER_IN);
    assign out_en = (dir == XFER_OUT);

    hdma_inbound #(.W(W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .en      (in_en),
        .stb     (stb),
        .wdata   (ext_wdata),
        .loc_ack (loc_ack),
        .rdata   (loc_rdata),
        .tx_free (tx_free),
        .rx_full (rx_full)
    );

    hdma_outbound #(.W(W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .en        (out_en),
        .ack_fall  (stb.fall),
        .loc_ack   (loc_ack),
        .loc_wdata (loc_wdata),
        .ob_data   (ob_data),
        .ob_full   (ob_full)
    );

    always_comb begin
        ext_req   = 1'b0;
        loc_req   = 1'b0;
        ext_rdata = '0;
        if (in_en) begin
            ext_req = tx_free;
            loc_req = rx_full;
        end else if (out_en) begin
            ext_req = ob_full;
            loc_req = !ob_full;
            if (ext_ack) ext_rdata = ob_data;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ext_req && !loc_req && ext_rdata == '0)); // R1

endmodule

// File: tb/test_hdma_port.sv
module test_hdma_port;
    import hdma_pkg::*;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         ctl_wr;
    logic [2:0]   ctl_wdata;
    logic         ext_ack;
    logic [W-1:0] ext_wdata;
    logic [W-1:0] ext_rdata;
    logic         ext_req;
    logic         loc_ack;
    logic [W-1:0] loc_wdata;
    logic [W-1:0] loc_rdata;
    logic         loc_req;

    int n_cmp = 0;
    int n_bad = 0;
    int bdir  = 0;
    logic [W-1:0] exp_q[$];

    always #10 clk = ~clk;

    hdma_port #(.W(W)) i_hdma_port (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ext_ack(ext_ack), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_req(ext_req), .loc_ack(loc_ack), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_req(loc_req)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: pops expected words as the design hands them out
    initial forever begin
        @(negedge clk);
        #2;
        if (bdir == 1 && loc_ack && loc_req) begin
            if (exp_q.size() == 0) check("R4 scoreboard underflow", loc_rdata, 'x);
            else check("R4 inbound word", loc_rdata, exp_q.pop_front());
        end else if (bdir == 2 && ext_ack && ext_req) begin
            if (exp_q.size() == 0) check("R7 scoreboard underflow", ext_rdata, 'x);
            else check("R7 outbound word", ext_rdata, exp_q.pop_front());
        end
    end

    task automatic set_ctl(logic [2:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic hwrite(logic [W-1:0] d);
        exp_q.push_back(d);
        ext_ack = 1'b1; ext_wdata = d;
        @(negedge clk);
        ext_ack = 1'b0; ext_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
    endtask

    task automatic lread();
        loc_ack = 1'b1;
        @(negedge clk);
        loc_ack = 1'b0;
    endtask

    task automatic lwrite(logic [W-1:0] d, bit expect_take);
        if (expect_take) exp_q.push_back(d);
        loc_ack = 1'b1; loc_wdata = d;
        @(negedge clk);
        loc_ack = 1'b0;
    endtask

    task automatic hread();
        ext_ack = 1'b1;
        @(negedge clk);
        ext_ack = 1'b0;
        #1 check("R9 rdata parked", ext_rdata, '0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] pats[4];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h1234_5678;
        rst = 1'b1; ctl_wr = 1'b0; ctl_wdata = '0; ext_ack = 1'b0;
        ext_wdata = '0; loc_ack = 1'b0; loc_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 ext_req", ext_req, 0);
        check("R1 loc_req", loc_req, 0);
        check("R1 ext_rdata", ext_rdata, 0);

        bdir = 1;
        set_ctl(3'b001);
        check("R2 ext_req empty", ext_req, 1);
        check("R2 loc_req", loc_req, 0);

        for (int i = 0; i < 4; i++) begin
            hwrite(pats[i]);
            check("R3 ext_req after fall", ext_req, 0);
            @(negedge clk);
            check("R3 ext_req re-raised", ext_req, 1);
            check("R3 loc_req raised", loc_req, 1);
            lread();
            check("R4 loc_req cleared", loc_req, 0);
        end

        // long acknowledge, last word wins
        exp_q.push_back(32'hC0DE_0003);
        ext_ack = 1'b1; ext_wdata = 32'hC0DE_0001;
        @(negedge clk); ext_wdata = 32'hC0DE_0002;
        @(negedge clk); ext_wdata = 32'hC0DE_0003;
        @(negedge clk); ext_ack = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R3 long ack loc_req", loc_req, 1);
        lread();

        // back-pressure
        hwrite(32'hAAAA_0001);
        @(negedge clk);
        hwrite(32'hBBBB_0002);
        check("R5 ext_req held low", ext_req, 0);
        repeat (3) @(negedge clk);
        check("R5 ext_req still low", ext_req, 0);
        check("R5 first word kept", loc_rdata, 32'hAAAA_0001);
        lread();
        check("R5 loc_req after read", loc_req, 0);
        check("R5 ext_req before move", ext_req, 0);
        @(negedge clk);
        check("R5 loc_req after move", loc_req, 1);
        check("R5 ext_req after move", ext_req, 1);
        check("R5 second word", loc_rdata, 32'hBBBB_0002);
        lread();

        // port off
        bdir = 0;
        set_ctl(3'b101);
        check("R8 alt ext_req", ext_req, 0);
        check("R8 alt loc_req", loc_req, 0);
        ext_ack = 1'b1; ext_wdata = 32'h5555_0000;
        @(negedge clk); ext_ack = 1'b0;
        @(negedge clk); @(negedge clk);
        set_ctl(3'b011);
        check("R8 both ext_req", ext_req, 0);
        check("R8 both loc_req", loc_req, 0);
        lread();
        set_ctl(3'b001);
        bdir = 1;
        check("R8 holding still empty", ext_req, 1);
        check("R8 receive still empty", loc_req, 0);

        // outbound
        bdir = 2;
        set_ctl(3'b010);
        check("R6 loc_req empty", loc_req, 1);
        check("R6 ext_req empty", ext_req, 0);
        check("R9 rdata idle", ext_rdata, 0);
        for (int i = 0; i < 4; i++) begin
            lwrite(~pats[i], 1'b1);
            check("R6 ext_req loaded", ext_req, 1);
            check("R6 loc_req loaded", loc_req, 0);
            hread();
            check("R7 ext_req drained", ext_req, 0);
            check("R7 loc_req drained", loc_req, 1);
        end
        lwrite(32'h0B0B_0001, 1'b1);
        lwrite(32'h0B0B_0002, 1'b0);
        check("R6 second load ignored", ext_req, 1);
        hread();

        check("R4 R7 scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule